// File: doc/BRIEF.md
# Block-Write Configuration Register Slave (I2C)

This block is a byte-oriented I2C target that owns six 8-bit configuration registers for a clock generator. Each register bit drives an enable for one of the generator's clock outputs. The block runs entirely in the system clock domain. It oversamples SCL and SDA through two-flop synchronizers and pulls SDA low through an open-drain output enable.

A host changes the registers with a block write to address 0xD2. The first two bytes after the address are a command code and a byte count. The block acknowledges both and discards them. Every byte after them loads the next register, starting at register 0 and counting upward. The host may end the write with a stop after any whole byte. A block read at address 0xD3 returns a byte count of 6, followed by the registers from 0 to 5, MSB first. The transfer goes on for as long as the host acknowledges each byte.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, register i holds byte i of the default vector: 0x0F, 0xFF, 0xFF, 0xF0, 0xA5, 0x3C for registers 0 to 5. `sda_oe` is low after reset.
- R2: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. After any other address byte, no byte is acknowledged and no register changes until the next start condition.
- R3: On a write, the two bytes that follow the address are acknowledged and change nothing. After them, the data bytes load registers 0, 1, 2, and so on in ascending order, and each data byte is acknowledged.
- R4: A stop after any whole byte leaves the registers already loaded with their new values. All other registers keep their previous contents.
- R5: Data bytes that arrive after register 5 has been loaded are still acknowledged, but they are discarded.
- R6: A read sends 0x06 first, then registers 0 to 5, each MSB first. A host acknowledge (SDA low) requests the next byte. A host not-acknowledge makes the block release SDA and go idle.
- R7: A stop or repeated start that arrives in the middle of a byte aborts the transfer. The partial byte is written nowhere. A repeated start begins a new address phase.
- R8: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. The block changes `sda_oe` only while SCL is low, so it never creates a start or stop on the bus itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| cfg_o | output | 48 | Register contents; register i on bits [8i+7:8i] |

## Verification
Every one of the 256 possible address bytes is sent. This shows that exactly 0xD2 and 0xD3 are acknowledged and that no other address has any effect on the registers. Block writes are made with two different data patterns and with command and count bytes that differ from the data. A dropped or misrouted dummy byte therefore shows up as a wrong register value. Writes are also stopped after two data bytes, carried on past register 5, and cut short mid-byte by a stop or by a repeated start. These runs separate three behaviours: a committed byte, a discarded overflow byte, and an aborted partial byte. Reads are checked both in full and with an early not-acknowledge after the count byte. A monitor flags any change of the SDA drive while SCL is high.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    // Protocol phases of the byte engine
    typedef enum logic [2:0] {
        ST_IDLE,   // ignore bus until a start condition
        ST_ADDR,   // shifting in the address byte
        ST_RX,     // shifting in a write byte
        ST_ACK,    // driving our acknowledge bit
        ST_TX,     // shifting out a read byte
        ST_MACK    // sampling the host acknowledge
    } xfer_st_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    // Index STAGES-1 is the synchronized level, index STAGES the previous one.
    logic [STAGES:0] scl_pipe_d, scl_pipe_q;
    logic [STAGES:0] sda_pipe_d, sda_pipe_q;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[STAGES-1:0], scl_i};
        sda_pipe_d = {sda_pipe_q[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = scl_pipe_q[STAGES-1];
    assign scl_prev = scl_pipe_q[STAGES];
    assign sda_now  = sda_pipe_q[STAGES-1];
    assign sda_prev = sda_pipe_q[STAGES];

    assign sda_s     = sda_now;
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int             NREG     = 6,
    parameter int             PTR_W    = 4,
    parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] ridx,
    output logic [7:0]       rdata,
    output logic [NREG*8-1:0] cfg_o
);

    logic [7:0] regs_d [NREG];
    logic [7:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = (we && widx == PTR_W'(i)) ? wdata : regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= DEFAULTS[i*8 +: 8];
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (ridx == PTR_W'(i)) rdata = regs_q[i];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign cfg_o[g*8 +: 8] = regs_q[g];
    end

    // R3
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (widx < PTR_W'(NREG)));

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_o));

endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
    import cfg_i2c_pkg::*;
#(
    parameter int         NREG  = 6,
    parameter int         PTR_W = 4,
    parameter logic [7:0] WADDR = 8'hD2,
    parameter logic [7:0] RADDR = 8'hD3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);

    localparam logic [PTR_W-1:0] DATA0  = PTR_W'(2);         // first data byte slot
    localparam logic [PTR_W-1:0] WR_END = PTR_W'(NREG + 2);  // write pointer ceiling
    localparam logic [PTR_W-1:0] RD_END = PTR_W'(NREG + 1);  // read pointer ceiling
    localparam logic [7:0]       COUNT  = 8'(NREG);

    typedef struct packed {
        xfer_st_e         st;
        logic [3:0]       bitcnt;
        logic [7:0]       shift;
        logic [PTR_W-1:0] idx;
        logic             rw;
        logic             oe;
        logic             mack;
    } xfer_s;

    xfer_s q, d;

    // Next read byte: slot 0 is the count, slots 1..NREG the registers.
    logic [PTR_W-1:0] n_load;
    logic [7:0]       tx_byte;

    always_comb begin
        if (q.st == ST_ACK)      n_load = '0;
        else if (q.idx < RD_END) n_load = q.idx + PTR_W'(1);
        else                     n_load = q.idx;
        rd_idx = n_load - PTR_W'(1);
        if (n_load == '0)                  tx_byte = COUNT;
        else if (n_load <= PTR_W'(NREG))   tx_byte = rd_data;
        else                               tx_byte = 8'hFF;
    end

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_idx  = q.idx - DATA0;
        wr_data = q.shift;
        if (stop_det) begin
            d.st     = ST_IDLE;
            d.oe     = 1'b0;
            d.bitcnt = '0;
        end else if (start_det) begin
            d.st     = ST_ADDR;
            d.oe     = 1'b0;
            d.bitcnt = '0;
            d.idx    = '0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.shift  = {q.shift[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.bitcnt = '0;
                        if (q.st == ST_ADDR) begin
                            d.idx = '0;
                            if (q.shift == WADDR) begin
                                d.rw = 1'b0;
                                d.oe = 1'b1;
                                d.st = ST_ACK;
                            end else if (q.shift == RADDR) begin
                                d.rw = 1'b1;
                                d.oe = 1'b1;
                                d.st = ST_ACK;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.oe = 1'b1;
                            d.st = ST_ACK;
                            if (q.idx >= DATA0 && q.idx < WR_END) wr_en = 1'b1;
                            if (q.idx < WR_END) d.idx = q.idx + PTR_W'(1);
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.bitcnt = '0;
                        if (!q.rw) begin
                            d.oe = 1'b0;
                            d.st = ST_RX;
                        end else begin
                            d.st    = ST_TX;
                            d.shift = tx_byte;
                            d.oe    = ~tx_byte[7];
                            d.idx   = n_load;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.oe     = 1'b0;
                            d.bitcnt = '0;
                            d.st     = ST_MACK;
                        end else begin
                            d.shift = {q.shift[6:0], 1'b1};
                            d.oe    = ~q.shift[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st     = ST_TX;
                            d.shift  = tx_byte;
                            d.oe     = ~tx_byte[7];
                            d.idx    = n_load;
                            d.bitcnt = '0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, bitcnt: '0, shift: '0, idx: '0,
                   rw: 1'b0, oe: 1'b0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

    // R7
    stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == ST_IDLE && !q.oe));

    // R7
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (q.st == ST_ADDR && q.bitcnt == 4'd0));

    // R8
    oe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> $past(scl_fall || start_det || stop_det));

    // R6
    tx_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TX || q.st == ST_MACK) |-> q.rw);

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
    parameter int                NREG     = 6,
    parameter int                STAGES   = 2,
    parameter logic [7:0]        WADDR    = 8'hD2,
    parameter logic [7:0]        RADDR    = 8'hD3,
    parameter logic [NREG*8-1:0] DEFAULTS = 48'h3C_A5_F0_FF_FF_0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [NREG*8-1:0] cfg_o
);

    localparam int PTR_W = $clog2(NREG + 3);

    logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [PTR_W-1:0] rd_idx, wr_idx;
    logic [7:0]       rd_data, wr_data;
    logic             wr_en;

    i2c_line_sync #(.STAGES(STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_xfer_fsm #(
        .NREG  (NREG),
        .PTR_W (PTR_W),
        .WADDR (WADDR),
        .RADDR (RADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    cfg_regfile #(
        .NREG     (NREG),
        .PTR_W    (PTR_W),
        .DEFAULTS (DEFAULTS)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .widx  (wr_idx),
        .wdata (wr_data),
        .ridx  (rd_idx),
        .rdata (rd_data),
        .cfg_o (cfg_o)
    );

endmodule

// File: tb/sim_cfg_i2c_slave.sv
module sim_cfg_i2c_slave;

    localparam int NR = 6;
    localparam int Q  = 6;   // clocks per quarter bit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [NR*8-1:0] cfg_o;

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    cfg_i2c_slave u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .cfg_o  (cfg_o)
    );

    int n_chk = 0;
    int n_err = 0;
    int oe_hi_changes = 0;
    int oe_changes = 0;
    logic [7:0] mdl [NR];

    // R8 monitor: the drive may only move while SCL is low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev) begin
            oe_changes++;
            if (m_scl) oe_hi_changes++;
        end
        oe_prev <= sda_oe;
    end

    function automatic logic [NR*8-1:0] packed_mdl();
        logic [NR*8-1:0] r;
        for (int i = 0; i < NR; i++) r[i*8 +: 8] = mdl[i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(Q);
        seen  = sda_bus; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) clock_bit(b[i], s);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        send_bits(b, 8);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~give_ack, s);
        m_sda = 1'b1;
    endtask

    task automatic blk_write(input string tag, input logic [7:0] cmd, input logic [7:0] cnt,
                             input int ndata, input logic [7:0] base, input logic [7:0] step);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, a); check({tag, " addr ack"}, a, 1'b1);
        send_byte(cmd, a);   check({tag, " cmd ack R3"}, a, 1'b1);
        send_byte(cnt, a);   check({tag, " count ack R3"}, a, 1'b1);
        for (int i = 0; i < ndata; i++) begin
            b = base + 8'(i) * step;
            send_byte(b, a);
            check($sformatf("%s data%0d ack", tag, i), a, 1'b1);
            if (i < NR) mdl[i] = b;
        end
        bus_stop();
        tick(4);
        check({tag, " cfg"}, cfg_o, packed_mdl());
    endtask

    task automatic blk_read(input string tag, input int nack_after);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, a); check({tag, " R6 read addr ack"}, a, 1'b1);
        recv_byte(nack_after > 0, b); check({tag, " R6 count"}, b, 8'h06);
        for (int i = 0; i < nack_after && i < NR; i++) begin
            recv_byte(i + 1 < nack_after, b);
            check($sformatf("%s R6 reg%0d", tag, i), b, mdl[i]);
        end
        tick(Q);
        check({tag, " R6 released"}, sda_oe, 1'b0);
        bus_stop();
        tick(4);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] b;
        mdl[0] = 8'h0F; mdl[1] = 8'hFF; mdl[2] = 8'hFF;
        mdl[3] = 8'hF0; mdl[4] = 8'hA5; mdl[5] = 8'h3C;
        tick(5);
        // R1 reset state
        check("R1 reset cfg", cfg_o, packed_mdl());
        check("R1 reset sda_oe", sda_oe, 1'b0);
        rst_n = 1'b1;
        tick(5);
        check("R1 cfg after release", cfg_o, packed_mdl());

        // R6 read back defaults
        blk_read("defaults", NR);

        // R3 two data patterns, dummy bytes differ from data
        blk_write("R3 patA", 8'h5A, 8'hC3, NR, 8'h10, 8'h11);
        blk_read("patA", NR);
        blk_write("R3 patB", 8'hA5, 8'h06, NR, 8'hF7, 8'h35);
        blk_read("patB", NR);

        // R4 stop after two data bytes
        blk_write("R4 partial", 8'h00, 8'h00, 2, 8'h81, 8'h42);

        // R5 overflow past last register
        blk_write("R5 overflow", 8'h00, 8'h08, NR + 2, 8'h3B, 8'h17);

        // R7 stop mid-byte: first data byte commits, second is partial
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h6E, a); mdl[0] = 8'h6E;
        send_bits(8'h00, 4);
        bus_stop();
        tick(4);
        check("R7 stop mid-byte cfg", cfg_o, packed_mdl());

        // R7 repeated start mid-byte, then a full read must work
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_bits(8'h00, 5);
        blk_read("R7 restart", NR);
        check("R7 restart cfg", cfg_o, packed_mdl());

        // R3 stop inside dummy phase changes nothing
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h99, a);
        bus_stop();
        tick(4);
        check("R3 stop after cmd cfg", cfg_o, packed_mdl());

        // R2 foreign address followed by bytes
        bus_start();
        send_byte(8'hA4, a); check("R2 foreign addr nack", a, 1'b0);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'h00, a);
            check("R2 foreign data nack", a, 1'b0);
        end
        bus_stop();
        tick(4);
        check("R2 foreign cfg", cfg_o, packed_mdl());

        // R6 host nack right after count
        blk_read("R6 early nack", 0);
        blk_write("R6 after early nack", 8'h00, 8'h00, 1, 8'hC9, 8'h00);

        // R2 sweep of all address bytes
        for (int adr = 0; adr < 256; adr++) begin
            bus_start();
            send_byte(8'(adr), a);
            check($sformatf("R2 addr %02h", adr), a, (adr == 8'hD2 || adr == 8'hD3));
            if (adr == 8'hD3) recv_byte(1'b0, b);
            bus_stop();
        end
        tick(4);
        check("R2 sweep cfg", cfg_o, packed_mdl());

        // R8 drive never moved with SCL high
        check("R8 oe edges with SCL high", oe_hi_changes, 0);
        check("R8 oe activity seen", oe_changes > 0, 1'b1);

        finish_run();
    end

endmodule